// File: doc/BRIEF.md
# Set/Clear Memory-Mapped GPIO Port

This block is a general-purpose I/O port with one pin per data bit, 32 by default, placed behind a small register bus. Software never has to read a register, change it and write it back to move one pin. Output level and output-driver enable are each changed through a pair of registers. One register of the pair raises the selected bits and the other lowers them. A bit written as 1 acts on its pin and a bit written as 0 leaves that pin alone.

Each pin has three pad signals: the level to drive, a drive enable for a tri-state pad, and the sampled input. Inputs pass through a two-stage synchronizer before software can read them at the status offset. The bus takes at most one request per cycle. A request is marked by `bus_sel`, and `bus_ready` answers it one cycle later. For a read, `bus_rdata` carries the data in that same cycle.

Top module: `gpio_setclr_port`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `pin_out`, `pin_oe`, `bus_rdata` and `bus_ready` are all 0.
- R2: A write to offset 0x00 sets `pin_out[n]` to 1 for every bit n that is 1 in `bus_wdata`. Pins whose bit is 0 keep their level. The change is visible the cycle after the request.
- R3: A write to offset 0x10 clears `pin_out[n]` to 0 for every bit n that is 1 in `bus_wdata`. Pins whose bit is 0 keep their level.
- R4: A write to offset 0x20 sets `pin_oe[n]` to 1 (driver on) for every bit n that is 1 in `bus_wdata`. All other enables are unchanged.
- R5: A write to offset 0x30 clears `pin_oe[n]` to 0 (high impedance) for every bit n that is 1 in `bus_wdata`. All other enables are unchanged.
- R6: A read of offset 0x40 returns the synchronized pin levels, with bit n being `pin_in[n]`. Suppose a change on `pin_in` comes just before clock edge E. A read sampled at E or at E+1 returns the old value, and a read sampled at E+2 or later returns the new one.
- R7: Reads of offsets 0x00, 0x10, 0x20, 0x30 and of any unmapped offset return 0. Writes to 0x40 or to any unmapped offset change neither `pin_out` nor `pin_oe`.
- R8: `bus_ready` is 1 exactly in the cycle after a cycle with `bus_sel` high. `bus_rdata` is 0 in every cycle that is not the answer to a read of 0x40.
- R9: `pin_out` and `pin_oe` hold their values in every cycle that follows a cycle with no write request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Request strobe, one request per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | NUM_PINS | Write data, one bit per pin |
| bus_rdata | output | NUM_PINS | Read data, valid when bus_ready is high |
| bus_ready | output | 1 | Request answered, one cycle after bus_sel |
| pin_out | output | NUM_PINS | Level driven on each pin |
| pin_oe | output | NUM_PINS | Output-driver enable for each pin |
| pin_in | input | NUM_PINS | Level seen on each pin |

## Verification
The assertions assume that `bus_sel`, `bus_we`, `bus_addr` and `bus_wdata` are synchronous to `clk` and hold a single request per cycle. They do not assume this of `pin_in`, which may change at any time. The stimulus changes every bus input only on the falling edge, and it leaves one idle cycle after each request so that each answer can be checked on its own. `pin_in` is also changed on the falling edge, so the two-stage latency of R6 falls on known clock edges.

// File: rtl/gpio_setclr_pkg.sv
package gpio_setclr_pkg;

  localparam logic [7:0] OFS_LVL_SET = 8'h00;
  localparam logic [7:0] OFS_LVL_CLR = 8'h10;
  localparam logic [7:0] OFS_DRV_ON  = 8'h20;
  localparam logic [7:0] OFS_DRV_OFF = 8'h30;
  localparam logic [7:0] OFS_PIN_RD  = 8'h40;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_LVL_SET,
    OP_LVL_CLR,
    OP_DRV_ON,
    OP_DRV_OFF,
    OP_PIN_RD
  } reg_op_e;

endpackage

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
  import gpio_setclr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output reg_op_e           op
);

  always_comb begin
    op = OP_NONE;
    if (sel) begin
      if (we) begin
        if      (addr == ADDR_W'(OFS_LVL_SET)) op = OP_LVL_SET;
        else if (addr == ADDR_W'(OFS_LVL_CLR)) op = OP_LVL_CLR;
        else if (addr == ADDR_W'(OFS_DRV_ON))  op = OP_DRV_ON;
        else if (addr == ADDR_W'(OFS_DRV_OFF)) op = OP_DRV_OFF;
      end else if (addr == ADDR_W'(OFS_PIN_RD)) begin
        op = OP_PIN_RD;
      end
    end
  end

endmodule

// File: rtl/gpio_setclr_bits.sv
module gpio_setclr_bits #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] set_mask,
  input  logic [WIDTH-1:0] clr_mask,
  output logic [WIDTH-1:0] bits_q
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)              bits_q[i] <= 1'b0;
      else if (set_mask[i]) bits_q[i] <= 1'b1;
      else if (clr_mask[i]) bits_q[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_setclr_port.sv
module gpio_setclr_port
  import gpio_setclr_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_sel,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [NUM_PINS-1:0] bus_wdata,
  output logic [NUM_PINS-1:0] bus_rdata,
  output logic                bus_ready,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  input  logic [NUM_PINS-1:0] pin_in
);

  localparam logic [NUM_PINS-1:0] NO_BITS = '0;

  reg_op_e             op;
  logic [NUM_PINS-1:0] lvl_set, lvl_clr, drv_on, drv_off;
  logic [NUM_PINS-1:0] pins_sync;

  gpio_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .sel  (bus_sel),
    .we   (bus_we),
    .addr (bus_addr),
    .op   (op)
  );

  assign lvl_set = (op == OP_LVL_SET) ? bus_wdata : NO_BITS;
  assign lvl_clr = (op == OP_LVL_CLR) ? bus_wdata : NO_BITS;
  assign drv_on  = (op == OP_DRV_ON)  ? bus_wdata : NO_BITS;
  assign drv_off = (op == OP_DRV_OFF) ? bus_wdata : NO_BITS;

  gpio_setclr_bits #(.WIDTH(NUM_PINS)) u_level (
    .clk      (clk),
    .rst      (rst),
    .set_mask (lvl_set),
    .clr_mask (lvl_clr),
    .bits_q   (pin_out)
  );

  gpio_setclr_bits #(.WIDTH(NUM_PINS)) u_drive (
    .clk      (clk),
    .rst      (rst),
    .set_mask (drv_on),
    .clr_mask (drv_off),
    .bits_q   (pin_oe)
  );

  gpio_in_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pin_in),
    .sync_out (pins_sync)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ready <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ready <= bus_sel;
      bus_rdata <= (op == OP_PIN_RD) ? pins_sync : NO_BITS;
    end
  end

endmodule

// File: rtl/gpio_setclr_port_chk.sv
module gpio_setclr_port_chk #(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_sel,
  input logic                bus_we,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [NUM_PINS-1:0] bus_wdata,
  input logic [NUM_PINS-1:0] bus_rdata,
  input logic                bus_ready,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe
);

  logic wr_req, rd_pins;
  assign wr_req  = bus_sel && bus_we;
  assign rd_pins = bus_sel && !bus_we && (bus_addr == ADDR_W'(8'h40));

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (pin_out == '0 && pin_oe == '0 && !bus_ready && bus_rdata == '0));

  assert_level_set_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_req && bus_addr == ADDR_W'(8'h00)) |=>
      (pin_out == ($past(pin_out) | $past(bus_wdata))));

  assert_level_clr_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_req && bus_addr == ADDR_W'(8'h10)) |=>
      (pin_out == ($past(pin_out) & ~$past(bus_wdata))));

  assert_drive_on_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_req && bus_addr == ADDR_W'(8'h20)) |=>
      (pin_oe == ($past(pin_oe) | $past(bus_wdata))));

  assert_drive_off_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_req && bus_addr == ADDR_W'(8'h30)) |=>
      (pin_oe == ($past(pin_oe) & ~$past(bus_wdata))));

  assert_other_read_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !rd_pins) |=> (bus_rdata == '0));

  assert_ready_on_req_R8: assert property (@(posedge clk) disable iff (rst)
    bus_sel |=> bus_ready);

  assert_ready_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !bus_sel |=> (!bus_ready && bus_rdata == '0));

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !wr_req |=> ($stable(pin_out) && $stable(pin_oe)));

endmodule

bind gpio_setclr_port gpio_setclr_port_chk #(
  .NUM_PINS (NUM_PINS),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .bus_ready (bus_ready),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe)
);

// File: tb/gpio_setclr_port_bench.sv
module gpio_setclr_port_bench;

  localparam int N  = 32;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_sel = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [N-1:0]  bus_wdata = '0;
  logic [N-1:0]  bus_rdata;
  logic          bus_ready;
  logic [N-1:0]  pin_out;
  logic [N-1:0]  pin_oe;
  logic [N-1:0]  pin_in = '0;

  gpio_setclr_port u_gpio_setclr_port (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_ready (bus_ready),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .pin_in    (pin_in)
  );

  always #2 clk = ~clk;

  typedef struct {
    logic [N-1:0] val;
    string        tag;
  } exp_t;

  exp_t         sb_q[$];
  int           n_checks = 0;
  int           n_fail = 0;
  logic [N-1:0] m_out = '0;
  logic [N-1:0] m_oe = '0;
  bit           done = 1'b0;

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && bus_ready) begin
      if (sb_q.size() == 0) begin
        check("R8 unexpected ready", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, bus_rdata, e.val);
      end
    end
  end

  task automatic bus_req(input logic we, input logic [AW-1:0] a,
                         input logic [N-1:0] d, input logic [N-1:0] exp_rd,
                         input string tag);
    exp_t e;
    e.val = exp_rd;
    e.tag = tag;
    sb_q.push_back(e);
    bus_sel   = 1'b1;
    bus_we    = we;
    bus_addr  = a;
    bus_wdata = d;
    @(negedge clk);
    bus_sel   = 1'b0;
    bus_we    = 1'b0;
    check("R8 ready after request", {31'd0, bus_ready}, 32'd1);
    @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [N-1:0] d, input string tag);
    case (a)
      8'h00: m_out = m_out | d;
      8'h10: m_out = m_out & ~d;
      8'h20: m_oe  = m_oe | d;
      8'h30: m_oe  = m_oe & ~d;
      default: ;
    endcase
    bus_req(1'b1, a, d, '0, {tag, " write rdata"});
    check({tag, " pin_out"}, pin_out, m_out);
    check({tag, " pin_oe"}, pin_oe, m_oe);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 pin_out in reset", pin_out, '0);
    check("R1 pin_oe in reset", pin_oe, '0);
    check("R1 ready in reset", {31'd0, bus_ready}, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rdata after reset", bus_rdata, '0);
    check("R8 idle ready low", {31'd0, bus_ready}, '0);

    wr(8'h00, 32'hA5A5_0F0F, "R2 set first");
    wr(8'h00, 32'h0000_00F0, "R2 set keeps others");
    wr(8'h10, 32'h0000_000F, "R3 clear low nibble");
    wr(8'h10, 32'hFFFF_0000, "R3 clear upper half");
    wr(8'h20, 32'h8000_0001, "R4 enable edges");
    wr(8'h20, 32'h0000_FF00, "R4 enable byte");
    wr(8'h30, 32'h0000_0F00, "R5 release nibble");
    wr(8'h30, 32'h0000_0000, "R5 zero mask no effect");
    wr(8'h40, 32'hFFFF_FFFF, "R7 write to status ignored");
    wr(8'h50, 32'hFFFF_FFFF, "R7 write unmapped ignored");
    wr(8'h08, 32'hFFFF_FFFF, "R7 write unaligned ignored");

    repeat (4) @(negedge clk);
    check("R9 pin_out held while idle", pin_out, m_out);
    check("R9 pin_oe held while idle", pin_oe, m_oe);

    bus_req(1'b0, 8'h00, '0, '0, "R7 read set level");
    bus_req(1'b0, 8'h10, '0, '0, "R7 read clear level");
    bus_req(1'b0, 8'h20, '0, '0, "R7 read drive on");
    bus_req(1'b0, 8'h30, '0, '0, "R7 read drive off");
    bus_req(1'b0, 8'h44, '0, '0, "R7 read unmapped");

    pin_in = 32'h1234_5678;
    repeat (3) @(negedge clk);
    bus_req(1'b0, 8'h40, '0, 32'h1234_5678, "R6 read pins");

    pin_in = 32'hCAFE_0001;
    bus_req(1'b0, 8'h40, '0, 32'h1234_5678, "R6 read at change edge old");
    bus_req(1'b0, 8'h40, '0, 32'hCAFE_0001, "R6 read two edges later new");

    pin_in = 32'h0000_0000;
    repeat (3) @(negedge clk);
    bus_req(1'b0, 8'h40, '0, 32'h0000_0000, "R6 read all low");

    repeat (2) @(negedge clk);
    check("R8 scoreboard drained", 32'(sb_q.size()), 32'd0);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule